// File: doc/BRIEF.md
# Auto-Repeat Pushbutton Reference Counter

This block turns one "up" pushbutton into an 8-bit reference value. A short press and release raises the value by one. If the button stays down long enough, the value starts stepping by itself at a fixed repeat rate for as long as the button is held. When the value reaches a configured ceiling it stops there. The next fresh press returns it to its starting value.

The raw button first goes through a two-flop synchronizer. A debounce stage follows, which accepts a new level only after the level has held steady for a set number of cycles. A six-state controller comes next. It shares one timer, and that timer restarts from zero on every state change. The value itself sits in a register that drives the output directly. The initial hold delay, the repeat interval, the debounce length, the starting value and the ceiling are all parameters. The controller's size does not depend on any of them.

Top module: `autorepeat_refcnt`

## Requirements
- R1: While reset is high, and right after it is released, `ref_val` equals INIT_VAL and `at_max` is low.
- R2: A raw high pulse that lasts fewer than DEB_CYC clock cycles leaves `ref_val` unchanged. The debounced level follows the synchronized level only after that level has differed from it for DEB_CYC consecutive cycles.
- R3: A press released before the hold delay runs out raises `ref_val` by exactly one, and only one.
- R4: With the button held, the first automatic increment appears DEB_CYC+HOLD_CYC+3 clock edges after the first edge that samples the raw press.
- R5: While the button stays held, each further automatic increment follows the previous one after exactly REPEAT_CYC+1 cycles. Releasing the button stops the repetition, with no further increment.
- R6: `ref_val` never goes above MAX_VAL and never wraps. `at_max` is high exactly when `ref_val` equals MAX_VAL. Holding the button at MAX_VAL changes nothing.
- R7: Once `ref_val` is at MAX_VAL, the next fresh press reloads INIT_VAL. That press adds no increment, however long it is held. The press after it counts normally.
- R8: The controller has six states, and the two increment states always pass to their successor on the next clock. The shared timer reads zero in the cycle after any state change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Raw, unsynchronized pushbutton level, high when pressed |
| ref_val | output | VAL_W | Current reference value |
| at_max | output | 1 | High while `ref_val` equals MAX_VAL |

## Verification
The bench times the first automatic step and each repeat step against cycle counts derived from the parameters. A timer that is not cleared on a state change, or that is off by one, moves these steps by a cycle. A glitch shorter than the debounce length is applied: a debounce that reacts to any single high sample would count it as a tap. The bench holds the button at the ceiling and presses again after reaching it. A design that wraps past the ceiling, or that re-arms without a release, either steps past MAX_VAL or increments during the reload press. The bench also releases the button right after a repeat step, which shows whether a release still lets one more step through.

// File: rtl/refcnt_pkg.sv
package refcnt_pkg;

    // Six controller states; TAP and AUTO are one-cycle increment states.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,   // button up, waiting
        ST_ARM  = 3'd1,   // button down, timing the first hold delay
        ST_TAP  = 3'd2,   // single step after a short press
        ST_RPT  = 3'd3,   // button down, timing the repeat interval
        ST_AUTO = 3'd4,   // automatic step
        ST_FULL = 3'd5    // wait for release (at ceiling or after reload)
    } ctl_st_e;

    // Debounced button view handed from the input path to the controller.
    typedef struct packed {
        logic level;
    } btn_view_t;

    function automatic int unsigned cnt_bits(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/refcnt_sync.sv
module refcnt_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= d_i;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '0;
                else     chain_q <= {chain_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/refcnt_debounce.sv
module refcnt_debounce
    import refcnt_pkg::*;
#(
    parameter int unsigned DEB_CYC = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl_i,
    output btn_view_t view_o
);
    localparam int unsigned CW = cnt_bits(DEB_CYC);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

    logic [CW-1:0] run_q;
    logic          db_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            db_q  <= 1'b0;
        end else if (lvl_i == db_q) begin
            run_q <= '0;
        end else if (run_q == LAST) begin
            run_q <= '0;
            db_q  <= lvl_i;
        end else begin
            run_q <= run_q + CW'(1);
        end
    end

    assign view_o.level = db_q;

    // R2: the debounced level only moves to a value its input already held
    a_r2_follow_input: assert property (@(posedge clk) disable iff (rst)
        !$stable(db_q) |-> ($past(lvl_i) == db_q));
endmodule

// File: rtl/refcnt_ctrl.sv
module refcnt_ctrl
    import refcnt_pkg::*;
#(
    parameter int unsigned VAL_W      = 8,
    parameter int unsigned INIT_VAL   = 0,
    parameter int unsigned MAX_VAL    = 255,
    parameter int unsigned HOLD_CYC   = 100_000_000,
    parameter int unsigned REPEAT_CYC = 25_000_000
) (
    input  logic             clk,
    input  logic             rst,
    input  btn_view_t        btn_i,
    output logic [VAL_W-1:0] val_o,
    output logic             full_o
);
    localparam int unsigned   TW        = cnt_bits(max2(HOLD_CYC, REPEAT_CYC));
    localparam logic [TW-1:0] HOLD_LAST = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] RPT_LAST  = TW'(REPEAT_CYC - 1);
    localparam logic [TW-1:0] TMR_TOP   = '1;
    localparam logic [VAL_W-1:0] INIT_V = VAL_W'(INIT_VAL);
    localparam logic [VAL_W-1:0] MAX_V  = VAL_W'(MAX_VAL);

    ctl_st_e          st_q, st_d;
    logic [TW-1:0]    tmr_q;
    logic [VAL_W-1:0] val_q, val_d;
    logic             top_hit, pressed;

    assign top_hit = (val_q == MAX_V);
    assign pressed = btn_i.level;

    always_comb begin
        st_d  = st_q;
        val_d = val_q;
        unique case (st_q)
            ST_IDLE: begin
                if (pressed) begin
                    if (top_hit) begin
                        val_d = INIT_V;
                        st_d  = ST_FULL;
                    end else begin
                        st_d  = ST_ARM;
                    end
                end
            end
            ST_ARM: begin
                if (!pressed)                st_d = ST_TAP;
                else if (tmr_q == HOLD_LAST) st_d = ST_AUTO;
            end
            ST_TAP: begin
                st_d = ST_IDLE;
                if (!top_hit) val_d = val_q + VAL_W'(1);
            end
            ST_RPT: begin
                if (top_hit)                st_d = ST_FULL;
                else if (!pressed)          st_d = ST_IDLE;
                else if (tmr_q == RPT_LAST) st_d = ST_AUTO;
            end
            ST_AUTO: begin
                st_d = ST_RPT;
                if (!top_hit) val_d = val_q + VAL_W'(1);
            end
            ST_FULL: begin
                if (!pressed) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            val_q <= INIT_V;
            tmr_q <= '0;
        end else begin
            st_q  <= st_d;
            val_q <= val_d;
            if (st_d != st_q)        tmr_q <= '0;
            else if (tmr_q != TMR_TOP) tmr_q <= tmr_q + TW'(1);
        end
    end

    assign val_o  = val_q;
    assign full_o = top_hit;

    // R6: value stays within the ceiling
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        val_q <= MAX_V);
    // R3: the value moves only by one step up or back to its start
    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(val_q) |-> ((val_q == $past(val_q) + VAL_W'(1)) || (val_q == INIT_V)));
    // R8: timer restarts after every state change
    a_r8_timer_clear: assert property (@(posedge clk) disable iff (rst)
        (st_d != st_q) |=> (tmr_q == '0));
    // R8: unconditional exits of the two step states
    a_r8_tap_exit: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_TAP) |=> (st_q == ST_IDLE));
    a_r8_auto_exit: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_AUTO) |=> (st_q == ST_RPT));
endmodule

// File: rtl/autorepeat_refcnt.sv
module autorepeat_refcnt
    import refcnt_pkg::*;
#(
    parameter int unsigned VAL_W      = 8,
    parameter int unsigned INIT_VAL   = 0,
    parameter int unsigned MAX_VAL    = 255,
    parameter int unsigned HOLD_CYC   = 100_000_000,
    parameter int unsigned REPEAT_CYC = 25_000_000,
    parameter int unsigned DEB_CYC    = 500_000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             btn_raw,
    output logic [VAL_W-1:0] ref_val,
    output logic             at_max
);
    logic      btn_sync;
    btn_view_t btn_db;

    refcnt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (btn_raw),
        .q_o (btn_sync)
    );

    refcnt_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (btn_sync),
        .view_o (btn_db)
    );

    refcnt_ctrl #(
        .VAL_W      (VAL_W),
        .INIT_VAL   (INIT_VAL),
        .MAX_VAL    (MAX_VAL),
        .HOLD_CYC   (HOLD_CYC),
        .REPEAT_CYC (REPEAT_CYC)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .btn_i  (btn_db),
        .val_o  (ref_val),
        .full_o (at_max)
    );

    // R6: flag and value agree at the ports
    a_r6_flag_match: assert property (@(posedge clk) disable iff (rst)
        at_max == (ref_val == VAL_W'(MAX_VAL)));
endmodule

// File: tb/tb_autorepeat_refcnt.sv
`timescale 1ns/1ps
module tb_autorepeat_refcnt;
    localparam int W = 8, INIT = 3, MAXV = 9, H = 12, R = 8, D = 3;

    logic clk = 1'b0, rst = 1'b1, btn = 1'b0;
    logic [W-1:0] ref_val;
    logic at_max;
    int cyc = 0, n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [W-1:0] exp_q[$];
    int           chg_q[$];
    logic [W-1:0] last_v;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    autorepeat_refcnt #(.VAL_W(W), .INIT_VAL(INIT), .MAX_VAL(MAXV), .HOLD_CYC(H),
        .REPEAT_CYC(R), .DEB_CYC(D)) dut (
        .clk(clk), .rst(rst), .btn_raw(btn), .ref_val(ref_val), .at_max(at_max));

    function automatic void check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endfunction

    // monitor: each change of the value is compared against the scoreboard queue
    always @(negedge clk) begin
        if (rst) last_v = ref_val;
        else if (ref_val !== last_v) begin
            if (exp_q.size() == 0) check(0, "R3/R6 unexpected change", int'(ref_val), int'(last_v));
            else begin
                check(ref_val == exp_q[0], "R3/R5 scoreboard", int'(ref_val), int'(exp_q[0]));
                void'(exp_q.pop_front());
            end
            chg_q.push_back(cyc);
            last_v = ref_val;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tap(input int len);
        @(negedge clk); btn = 1'b1;
        wait_n(len);
        btn = 1'b0;
        wait_n(12);
    endtask

    task automatic drain;
        int guard = 0;
        while (exp_q.size() != 0 && guard < 200) begin @(negedge clk); guard++; end
    endtask

    task automatic summary;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        int press_cyc;
        wait_n(4);
        check(ref_val == INIT, "R1 value in reset", int'(ref_val), INIT);
        rst = 1'b0;
        wait_n(2);
        check(ref_val == INIT, "R1 value after reset", int'(ref_val), INIT);
        check(at_max == 1'b0, "R1 flag after reset", int'(at_max), 0);

        // R3: two short taps
        exp_q.push_back(4); tap(6);
        exp_q.push_back(5); tap(6);
        check(exp_q.size() == 0, "R3 taps consumed", exp_q.size(), 0);

        // R2: glitch shorter than the debounce length
        @(negedge clk); btn = 1'b1; wait_n(2); btn = 1'b0;
        wait_n(20);
        check(ref_val == 5, "R2 glitch ignored", int'(ref_val), 5);

        // R4/R5/R6: long hold runs up to the ceiling
        chg_q.delete();
        for (int v = 6; v <= MAXV; v++) exp_q.push_back(W'(v));
        @(negedge clk); btn = 1'b1; press_cyc = cyc;
        wait_n(70);
        check(chg_q.size() == 4, "R5 repeat count", chg_q.size(), 4);
        if (chg_q.size() == 4) begin
            check(chg_q[0] == press_cyc + D + H + 4, "R4 first auto step", chg_q[0], press_cyc + D + H + 4);
            for (int i = 1; i < 4; i++)
                check(chg_q[i] - chg_q[i-1] == R + 1, "R5/R8 repeat spacing", chg_q[i] - chg_q[i-1], R + 1);
        end
        check(ref_val == MAXV, "R6 held at ceiling", int'(ref_val), MAXV);
        check(at_max == 1'b1, "R6 flag at ceiling", int'(at_max), 1);
        btn = 1'b0; wait_n(15);
        check(ref_val == MAXV, "R6 stays after release", int'(ref_val), MAXV);

        // R7: fresh press reloads the start value, no step while held
        exp_q.push_back(INIT);
        @(negedge clk); btn = 1'b1; wait_n(50);
        check(ref_val == INIT, "R7 reload on press", int'(ref_val), INIT);
        check(at_max == 1'b0, "R7 flag cleared", int'(at_max), 0);
        btn = 1'b0; wait_n(12);
        exp_q.push_back(INIT + 1); tap(6);
        check(ref_val == INIT + 1, "R7 next tap counts", int'(ref_val), INIT + 1);

        // R5: release right after a repeat step stops it
        exp_q.push_back(5); exp_q.push_back(6);
        @(negedge clk); btn = 1'b1;
        drain();
        btn = 1'b0; wait_n(30);
        check(ref_val == 6, "R5 release stops repeat", int'(ref_val), 6);

        // R6/R7: taps up to the ceiling, then a tap reloads
        for (int v = 7; v <= MAXV; v++) begin exp_q.push_back(W'(v)); tap(6); end
        check(at_max == 1'b1, "R6 ceiling by taps", int'(at_max), 1);
        exp_q.push_back(INIT); tap(6);
        check(ref_val == INIT, "R7 tap at ceiling reloads", int'(ref_val), INIT);
        exp_q.push_back(INIT + 1); tap(6);

        // R1: reset mid-run
        @(negedge clk); rst = 1'b1; wait_n(2);
        check(ref_val == INIT, "R1 mid-run reset", int'(ref_val), INIT);
        rst = 1'b0; wait_n(2);
        check(exp_q.size() == 0, "R3 scoreboard empty", exp_q.size(), 0);

        done = 1;
        summary();
        $finish;
    end
endmodule